// File: doc/BRIEF.md
# Frame Count Interrupt Coalescer

This block sits between a frame receiver and the processor's interrupt line. Each completed frame arrives as a one-cycle pulse. The block counts these pulses, and it raises its interrupt only when the count reaches a threshold that software sets. Software can then service a whole batch of frames for the cost of one interrupt.

A fallback timer covers traffic that stops before the threshold is reached. The timer starts on the first frame of a batch and runs for a programmable number of cycles. When it runs out, the interrupt is raised even though fewer frames than the threshold have arrived. The interrupt is a level that stays latched until software acknowledges it. An enable input gates it onto the output. The number of frames not yet acknowledged can be read at all times.

The acknowledge clears both the count and the latched interrupt. A frame that arrives in the same cycle as the acknowledge opens the next batch, so no frame is lost.

Top module: `frame_coalescer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `irq_o` is 0 and `pending_o` is 0.
- R2: Each cycle with `frame_done_i` = 1 and `ack_i` = 0 raises `pending_o` by exactly one in the following cycle, unless the count is at its maximum.
- R3: `pending_o` saturates at 2^CNT_W-1. It holds that value while further frames arrive and never wraps to zero.
- R4: With an effective threshold T, the latched interrupt sets in the cycle after the frame that brings the count to T. It does not set for any smaller count unless the timer expires first.
- R5: A threshold of 0 behaves like a threshold of 1, so every frame raises the interrupt in the following cycle.
- R6: When `timeout_i` = N is non-zero and the threshold has not been reached, the interrupt sets N cycles after the clock edge that counted the first frame of the batch. With `timeout_i` = 0 the timer never raises the interrupt.
- R7: Frames after the first one of a batch do not restart the timer. The expiry stays N cycles after the first frame.
- R8: `ack_i` = 1 clears the count and the latched interrupt in the next cycle. If `frame_done_i` = 1 in the same cycle, `pending_o` is 1 afterwards. That frame starts a new batch: it starts the timer, and it raises the interrupt if the threshold is 0 or 1.
- R9: `irq_o` equals the latched interrupt AND `irq_en_i`. Holding `irq_en_i` at 0 does not stop counting and does not clear the latched event. Setting `irq_en_i` back to 1 shows a pending event at once.
- R10: Once set, the latched interrupt stays set until `ack_i`, whatever further frames arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_done_i | input | 1 | One-cycle pulse per completed frame |
| thresh_i | input | CNT_W | Frame count that raises the interrupt (0 acts as 1) |
| timeout_i | input | TMR_W | Fallback delay in cycles from the first frame (0 disables the timer) |
| irq_en_i | input | 1 | Interrupt enable (1 lets the latched event through) |
| ack_i | input | 1 | Software acknowledge; clears count and interrupt |
| irq_o | output | 1 | Level interrupt to the core |
| pending_o | output | CNT_W | Frames counted since the last acknowledge |

## Verification
The bound checker watches several properties on every cycle. It checks the count step, saturation without wrap, the interrupt setting after a frame that reaches the threshold (including the threshold 0 and 1 case), the latch holding until acknowledge, the acknowledge results with and without a simultaneous frame, and that the timer stays silent while disabled. The exact expiry cycle cannot be seen by the per-cycle properties. Neither can the fact that later frames leave the timer alone, or that masking keeps the event latched. Only the bench's scenarios show these, measuring cycle distances from the first frame and toggling the enable against a behavioural model.

// File: rtl/coal_pkg.sv
package coal_pkg;

  // Fallback timer state: waiting for the first frame of a batch, or counting.
  typedef enum logic {
    TMR_IDLE = 1'b0,
    TMR_RUN  = 1'b1
  } tmr_state_e;

  // Source of the next-state value of the frame counter.
  typedef enum logic [1:0] {
    CNT_HOLD  = 2'd0,
    CNT_STEP  = 2'd1,
    CNT_CLEAR = 2'd2,
    CNT_RESTART = 2'd3
  } cnt_op_e;

endpackage

// File: rtl/frame_counter.sv
module frame_counter
  import coal_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_i,
  input  logic          ack_i,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] cnt_next_o,
  output logic          first_o,
  output logic          sat_o
);

  localparam logic [CW-1:0] CNT_MAX = '1;
  localparam logic [CW-1:0] CNT_ONE = {{(CW-1){1'b0}}, 1'b1};

  // Increment that sticks at the top value.
  function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] v);
    logic [CW-1:0] r;
    r = (v == CNT_MAX) ? v : v + CNT_ONE;
    return r;
  endfunction

  logic [CW-1:0] cnt_q;
  cnt_op_e       op;

  // The acknowledge wins over counting; a frame in the same cycle opens a new batch.
  always_comb begin
    if (ack_i && frame_i)  op = CNT_RESTART;
    else if (ack_i)        op = CNT_CLEAR;
    else if (frame_i)      op = CNT_STEP;
    else                   op = CNT_HOLD;
  end

  always_comb begin
    unique case (op)
      CNT_RESTART: cnt_next_o = CNT_ONE;
      CNT_CLEAR:   cnt_next_o = '0;
      CNT_STEP:    cnt_next_o = sat_inc(cnt_q);
      default:     cnt_next_o = cnt_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_next_o;
  end

  // First frame of a batch: the count was empty, or it is being cleared now.
  assign first_o = frame_i && (ack_i || (cnt_q == '0));
  assign sat_o   = (cnt_q == CNT_MAX);
  assign cnt_o   = cnt_q;

endmodule

// File: rtl/threshold_cmp.sv
module threshold_cmp #(
  parameter int CW = 8
) (
  input  logic [CW-1:0] thresh_i,
  input  logic [CW-1:0] cnt_next_i,
  output logic          hit_o
);

  localparam logic [CW-1:0] THR_ONE = {{(CW-1){1'b0}}, 1'b1};

  // A zero threshold is treated as one frame.
  function automatic logic [CW-1:0] eff_thresh(input logic [CW-1:0] t);
    logic [CW-1:0] r;
    r = (t == '0) ? THR_ONE : t;
    return r;
  endfunction

  // Reached when the count after this edge is non-empty and at or above the limit.
  function automatic logic reached(input logic [CW-1:0] c, input logic [CW-1:0] t);
    logic r;
    r = (c != '0) && (c >= eff_thresh(t));
    return r;
  endfunction

  assign hit_o = reached(cnt_next_i, thresh_i);

endmodule

// File: rtl/batch_timer.sv
module batch_timer
  import coal_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          ack_i,
  input  logic          halt_i,
  input  logic [TW-1:0] timeout_i,
  output logic          expire_o,
  output logic          running_o
);

  localparam logic [TW-1:0] EL_MAX = '1;
  localparam logic [TW:0]   EL_ONE = {{TW{1'b0}}, 1'b1};

  // Expiry test: the edge that would make the elapsed count reach the limit.
  function automatic logic limit_reached(input logic [TW-1:0] el, input logic [TW-1:0] lim);
    logic [TW:0] nxt;
    logic        r;
    nxt = {1'b0, el} + EL_ONE;
    r   = (lim != '0) && (nxt >= {1'b0, lim});
    return r;
  endfunction

  function automatic logic [TW-1:0] el_inc(input logic [TW-1:0] el);
    logic [TW-1:0] r;
    r = (el == EL_MAX) ? el : el + {{(TW-1){1'b0}}, 1'b1};
    return r;
  endfunction

  tmr_state_e    state_q;
  logic [TW-1:0] elapsed_q;

  assign expire_o  = (state_q == TMR_RUN) && !halt_i && !ack_i &&
                     limit_reached(elapsed_q, timeout_i);
  assign running_o = (state_q == TMR_RUN);

  // Only the first frame of a batch (start_i) loads the timer.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= TMR_IDLE;
      elapsed_q <= '0;
    end else if (start_i) begin
      state_q   <= TMR_RUN;
      elapsed_q <= '0;
    end else if (ack_i) begin
      state_q   <= TMR_IDLE;
      elapsed_q <= '0;
    end else if (state_q == TMR_RUN) begin
      if (halt_i || expire_o) begin
        state_q <= TMR_IDLE;
      end else begin
        elapsed_q <= el_inc(elapsed_q);
      end
    end
  end

endmodule

// File: rtl/irq_latch.sv
module irq_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_i,
  input  logic count_hit_i,
  input  logic timer_hit_i,
  input  logic en_i,
  output logic fire_o,
  output logic irq_o
);

  logic fire_q;
  logic fire_d;

  // The acknowledge drops the old event; a restarting batch may raise it again.
  always_comb begin
    if (ack_i) fire_d = count_hit_i;
    else       fire_d = fire_q || count_hit_i || timer_hit_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) fire_q <= 1'b0;
    else        fire_q <= fire_d;
  end

  assign fire_o = fire_q;
  assign irq_o  = fire_q && en_i;

endmodule

// File: rtl/frame_coalescer.sv
module frame_coalescer #(
  parameter int CNT_W = 8,
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_done_i,
  input  logic [CNT_W-1:0] thresh_i,
  input  logic [TMR_W-1:0] timeout_i,
  input  logic             irq_en_i,
  input  logic             ack_i,
  output logic             irq_o,
  output logic [CNT_W-1:0] pending_o
);

  // Named internal events, visible to the bound checker.
  logic [CNT_W-1:0] cnt_next_w;
  logic             first_frame_w;
  logic             cnt_sat_w;
  logic             count_hit_w;
  logic             timer_expire_w;
  logic             timer_run_w;
  logic             fire_w;

  frame_counter #(.CW(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_i    (frame_done_i),
    .ack_i      (ack_i),
    .cnt_o      (pending_o),
    .cnt_next_o (cnt_next_w),
    .first_o    (first_frame_w),
    .sat_o      (cnt_sat_w)
  );

  threshold_cmp #(.CW(CNT_W)) u_thr (
    .thresh_i   (thresh_i),
    .cnt_next_i (cnt_next_w),
    .hit_o      (count_hit_w)
  );

  batch_timer #(.TW(TMR_W)) u_tmr (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (first_frame_w),
    .ack_i     (ack_i),
    .halt_i    (fire_w),
    .timeout_i (timeout_i),
    .expire_o  (timer_expire_w),
    .running_o (timer_run_w)
  );

  irq_latch u_irq (
    .clk         (clk),
    .rst_n       (rst_n),
    .ack_i       (ack_i),
    .count_hit_i (count_hit_w),
    .timer_hit_i (timer_expire_w),
    .en_i        (irq_en_i),
    .fire_o      (fire_w),
    .irq_o       (irq_o)
  );

endmodule

// File: rtl/coal_chk.sv
module coal_chk #(
  parameter int CNT_W = 8,
  parameter int TMR_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_done_i,
  input logic [CNT_W-1:0] thresh_i,
  input logic [TMR_W-1:0] timeout_i,
  input logic             irq_en_i,
  input logic             ack_i,
  input logic             irq_o,
  input logic [CNT_W-1:0] pending_o,
  input logic             cnt_sat_w,
  input logic             timer_expire_w,
  input logic             timer_run_w,
  input logic             fire_w
);

  localparam logic [CNT_W-1:0] C_ONE = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W:0]   W_ONE = {{CNT_W{1'b0}}, 1'b1};

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (pending_o == '0) && !irq_o);

  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_i && frame_done_i && !cnt_sat_w |=> pending_o == $past(pending_o) + C_ONE);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_i && cnt_sat_w |=> cnt_sat_w);

  p_no_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_i && (pending_o != '0) |=> pending_o != '0);

  p_thr_fire_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_i && frame_done_i && (({1'b0, pending_o} + W_ONE) >= {1'b0, thresh_i}) |=> fire_w);

  p_every_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_i && (thresh_i <= C_ONE) |=> fire_w && (pending_o != '0));

  p_timer_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_i == '0) |-> !timer_expire_w);

  p_timer_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    timer_expire_w |-> (pending_o != '0) && timer_run_w);

  p_ack_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i && !frame_done_i |=> (pending_o == '0) && !fire_w);

  p_ack_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i && frame_done_i |=> pending_o == C_ONE);

  p_enable_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_en_i && fire_w |-> irq_o);

  p_level_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fire_w && !ack_i |=> fire_w);

endmodule

bind frame_coalescer coal_chk #(.CNT_W(CNT_W), .TMR_W(TMR_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .frame_done_i   (frame_done_i),
  .thresh_i       (thresh_i),
  .timeout_i      (timeout_i),
  .irq_en_i       (irq_en_i),
  .ack_i          (ack_i),
  .irq_o          (irq_o),
  .pending_o      (pending_o),
  .cnt_sat_w      (cnt_sat_w),
  .timer_expire_w (timer_expire_w),
  .timer_run_w    (timer_run_w),
  .fire_w         (fire_w)
);

// File: tb/tb_frame_coalescer.sv
module tb_frame_coalescer;

  localparam int CLK_P = 10;
  localparam int CW    = 8;
  localparam int TW    = 16;
  localparam int CMAX  = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          frame = 1'b0;
  logic          ack = 1'b0;
  logic          en = 1'b1;
  logic [CW-1:0] thr = '0;
  logic [TW-1:0] tmo = '0;
  logic          irq;
  logic [CW-1:0] pend;

  int    errors = 0;
  int    checks = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  // Behavioural reference state.
  int m_cnt = 0;
  bit m_fire = 1'b0;
  bit m_started = 1'b0;
  int m_start = 0;
  int cyc = 0;

  frame_coalescer #(.CNT_W(CW), .TMR_W(TW)) dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_done_i (frame),
    .thresh_i     (thr),
    .timeout_i    (tmo),
    .irq_en_i     (en),
    .ack_i        (ack),
    .irq_o        (irq),
    .pending_o    (pend)
  );

  always #(CLK_P/2) clk = ~clk;

  // Model update on each edge, then compare a quarter period later.
  always @(posedge clk) begin
    bit fire_prev;
    int eff;
    if (!rst_n) begin
      m_cnt = 0; m_fire = 1'b0; m_started = 1'b0; m_start = 0;
    end else begin
      fire_prev = m_fire;
      if (ack) begin
        m_cnt = frame ? 1 : 0;
        m_fire = 1'b0;
        m_started = frame;
        m_start = cyc;
      end else begin
        if (frame) begin
          if (m_cnt == 0) begin m_started = 1'b1; m_start = cyc; end
          if (m_cnt < CMAX) m_cnt = m_cnt + 1;
        end
        if (!fire_prev && m_started && tmo != 0 && (cyc - m_start) >= int'(tmo))
          m_fire = 1'b1;
      end
      eff = (thr == 0) ? 1 : int'(thr);
      if (m_cnt != 0 && m_cnt >= eff) m_fire = 1'b1;
    end
    cyc = cyc + 1;
    #(CLK_P/4);
    if (rst_n && !done) begin
      checks = checks + 1;
      if (irq !== (m_fire && en)) begin
        errors = errors + 1;
        $display("FAIL %s cycle %0d irq actual=%0b expected=%0b", cur_req, cyc, irq, m_fire && en);
      end
      checks = checks + 1;
      if (int'(pend) != m_cnt) begin
        errors = errors + 1;
        $display("FAIL %s cycle %0d pending actual=%0d expected=%0d", cur_req, cyc, pend, m_cnt);
      end
    end
  end

  task automatic step(input logic f, input logic a);
    frame = f; ack = a;
    @(negedge clk);
    frame = 1'b0; ack = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(input logic e_irq, input int e_pend, input string req);
    #1;
    checks = checks + 1;
    if (irq !== e_irq || int'(pend) != e_pend) begin
      errors = errors + 1;
      $display("FAIL %s irq/pending actual=%0b/%0d expected=%0b/%0d", req, irq, pend, e_irq, e_pend);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    errors = errors + 1;
    checks = checks + 1;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    // R1: reset state
    cur_req = "R1";
    repeat (3) @(negedge clk);
    expect_out(1'b0, 0, "R1");
    rst_n = 1'b1;
    @(negedge clk);
    expect_out(1'b0, 0, "R1");

    // R2 / R4: threshold of four, spaced frames
    cur_req = "R4"; thr = 8'd4; tmo = '0;
    for (int i = 0; i < 3; i++) begin step(1'b1, 1'b0); idle(2); end
    expect_out(1'b0, 3, "R2");
    step(1'b1, 1'b0);
    expect_out(1'b1, 4, "R4");
    step(1'b0, 1'b1);
    expect_out(1'b0, 0, "R8");

    // R4 back-to-back frames
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0);
    expect_out(1'b1, 4, "R4");
    step(1'b0, 1'b1);

    // R5: threshold 0 and 1
    cur_req = "R5"; thr = 8'd0;
    step(1'b1, 1'b0);
    expect_out(1'b1, 1, "R5");
    step(1'b0, 1'b1);
    thr = 8'd1;
    step(1'b1, 1'b0);
    expect_out(1'b1, 1, "R5");
    step(1'b0, 1'b1);

    // R6: timer fallback and disabled timer
    cur_req = "R6"; thr = 8'd10; tmo = 16'd20;
    step(1'b1, 1'b0);
    idle(19);
    expect_out(1'b0, 1, "R6");
    idle(1);
    expect_out(1'b1, 1, "R6");
    step(1'b0, 1'b1);
    tmo = '0;
    step(1'b1, 1'b0);
    idle(40);
    expect_out(1'b0, 1, "R6");
    step(1'b0, 1'b1);

    // R7: later frames do not restart the timer
    cur_req = "R7"; tmo = 16'd15;
    step(1'b1, 1'b0);
    for (int i = 0; i < 2; i++) begin idle(4); step(1'b1, 1'b0); end
    idle(4);
    expect_out(1'b0, 3, "R7");
    idle(1);
    expect_out(1'b1, 3, "R7");
    step(1'b0, 1'b1);

    // R8: acknowledge with a simultaneous frame
    cur_req = "R8"; thr = 8'd5; tmo = '0;
    step(1'b1, 1'b0); step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    expect_out(1'b0, 1, "R8");
    step(1'b0, 1'b1);
    thr = 8'd1;
    step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    expect_out(1'b1, 1, "R8");
    step(1'b0, 1'b1);
    // timer restarts on the frame that comes with the acknowledge
    thr = 8'd10; tmo = 16'd8;
    step(1'b1, 1'b0);
    idle(3);
    step(1'b1, 1'b1);
    idle(7);
    expect_out(1'b0, 1, "R8");
    idle(1);
    expect_out(1'b1, 1, "R8");
    step(1'b0, 1'b1);

    // R9: enable gating keeps the event latched
    cur_req = "R9"; en = 1'b0; thr = 8'd2; tmo = '0;
    step(1'b1, 1'b0); step(1'b1, 1'b0);
    expect_out(1'b0, 2, "R9");
    en = 1'b1;
    expect_out(1'b1, 2, "R9");
    en = 1'b0;
    expect_out(1'b0, 2, "R9");
    idle(2);
    en = 1'b1;
    expect_out(1'b1, 2, "R9");

    // R10: level stays until acknowledge
    cur_req = "R10";
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0);
    idle(10);
    expect_out(1'b1, 5, "R10");
    step(1'b0, 1'b1);
    expect_out(1'b0, 0, "R10");

    // R3: saturation at the top count
    cur_req = "R3"; thr = 8'd255;
    for (int i = 0; i < 270; i++) step(1'b1, 1'b0);
    expect_out(1'b1, CMAX, "R3");
    idle(3);
    expect_out(1'b1, CMAX, "R3");
    step(1'b0, 1'b1);
    expect_out(1'b0, 0, "R3");

    idle(2);
    finish_run();
  end

endmodule